// File: doc/BRIEF.md
# Event-Freezing Sample FIFO Controller

This block stores three-axis sample words in a FIFO and ties that FIFO to a motion-wake event detector. A configuration register controls how they work together. In stream mode the FIFO always keeps the newest samples: a sample that arrives while the FIFO is full pushes out the oldest entry. The detector produces a latched wake interrupt. When the freeze option is set, capture stops while that interrupt is asserted. The samples that led up to the event then stay in the FIFO for software to read.

The detector takes one event, latches it, and ignores later events until it is re-armed. The re-arm bit selects how that happens. Either clearing the interrupt re-arms the detector, or the detector re-arms only when the device leaves wake mode. Capture happens only when at least one of three interface-enable bits is set. Software reads the FIFO through a show-ahead port and can see the full flag, the entry count and a sticky overflow flag.

Top module: `wake_fifo_ctrl`

## Requirements
- R1: After reset the configuration reads 0x00, the wake interrupt is low, the FIFO is empty with count 0, and the overflow flag is 0.
- R2: Configuration bits [2:0] always read 0 whatever is written. Bits [7:3] read back as written: [3] freeze, [4] re-arm, [7:5] interface enables.
- R3: While configuration bits [7:5] are all 0, offered samples are not captured and the count does not change.
- R4: Outside stream mode the FIFO returns samples in arrival order and is full at DEPTH entries. Samples offered while it is full are dropped, the count stays at DEPTH and the overflow flag stays 0.
- R5: In stream mode, a sample offered while the FIFO is full discards the oldest entry and is stored. The count stays at DEPTH, and the sticky overflow flag sets and stays set.
- R6: An event pulse in wake mode, with the detector armed, raises the wake interrupt on the next cycle. The interrupt then holds until it is cleared. Events while wake mode is off are ignored.
- R7: With freeze at 0, samples keep being captured while the wake interrupt is high.
- R8: With freeze at 1, samples offered while the interrupt is high are not captured. A sample offered in the same cycle as the event is still captured, and reads stay allowed.
- R9: After the interrupt is cleared, capture resumes with the next offered sample. Samples refused during the freeze are not back-filled.
- R10: With re-arm at 0, events after a clear are ignored until wake mode has been off for at least one cycle.
- R11: With re-arm at 1, clearing the interrupt re-arms the detector, so the next event raises the interrupt again.
- R12: When a clear strobe and an event arrive in the same cycle, the interrupt is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 48 | Packed three-axis sample |
| stream_mode | input | 1 | 1: keep newest samples when full |
| wake_evt | input | 1 | Single-cycle event pulse from detector logic |
| wake_mode_on | input | 1 | Device is in wake mode; 0 resets the detector |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| irq_clr | input | 1 | Single-cycle interrupt clear strobe |
| wake_irq | output | 1 | Latched wake interrupt |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 48 | Head entry (0 when empty) |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_count | output | 6 | Number of entries held |
| fifo_ovf | output | 1 | Sticky: stream mode discarded an entry |

## Verification
The two functions that can fall in the same cycle are the interrupt clear and a new event. The bench pulses both in one cycle, once while the interrupt is high and once while it is low with the detector armed. In both cases it expects the interrupt low on the next cycle. A second collision is a sample offered in the same cycle as the event under freeze. That sample must still be stored, and the next sample must be refused.

// File: rtl/wfc_pkg.sv
package wfc_pkg;
  localparam int CFG_W = 8;

  typedef struct packed {
    logic [2:0] iface;
    logic       rearm;
    logic       freeze;
  } wfc_cfg_t;
endpackage

// File: rtl/wfc_cfg.sv
module wfc_cfg
  import wfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output wfc_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  wfc_cfg_t cfg_q, cfg_d;
  logic     unused_rsvd;

  assign unused_rsvd = ^wdata[2:0];

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wfc_cfg_t'(wdata[CFG_W-1:3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = {cfg_q, 3'b000};

  // R2: a write is reflected in the upper bits on the following cycle
  a_r2_wr_back: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata[CFG_W-1:3] == $past(wdata[CFG_W-1:3]));
endmodule

// File: rtl/wfc_wake.sv
module wfc_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wake_mode,
  input  logic clr,
  input  logic rearm,
  output logic irq
);
  logic irq_q, irq_d;
  logic armed_q, armed_d;

  always_comb begin
    irq_d   = irq_q;
    armed_d = armed_q;
    if (!wake_mode) begin
      armed_d = 1'b1;
      if (clr) irq_d = 1'b0;
    end else if (clr) begin
      irq_d = 1'b0;
      if (rearm) armed_d = 1'b1;
    end else if (evt && armed_q) begin
      irq_d   = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      irq_q   <= irq_d;
      armed_q <= armed_d;
    end
  end

  assign irq = irq_q;

  // R12: clear dominates any same-cycle event
  a_r12_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
  // R6: latched interrupt holds until cleared
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  // R10: a disarmed detector cannot raise the interrupt
  a_r10_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && wake_mode && !(clr && rearm)) |=> !$rose(irq));
endmodule

// File: rtl/wfc_fifo.sv
module wfc_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 48,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  input  logic          stream,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          do_pop, wr_ok, drop_old, adv_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full     = (cnt_q == FULL_CNT);
  assign empty    = (cnt_q == '0);
  assign do_pop   = pop && !empty;
  assign wr_ok    = push && (!full || stream || do_pop);
  assign drop_old = push && full && stream && !do_pop;
  assign adv_rd   = do_pop || drop_old;

  always_comb begin
    wr_ptr_d = wr_ok  ? nxt(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = adv_rd ? nxt(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_ok && !adv_rd)      cnt_d = cnt_q + CW'(1);
    else if (!wr_ok && adv_rd) cnt_d = cnt_q - CW'(1);
    ovf_d    = ovf_q | drop_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem[rd_ptr_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R4: occupancy never exceeds the depth
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R4: a refused write when full leaves the overflow flag untouched
  a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !stream && !do_pop) |=> (full && $stable(ovf_q)));
  // R5: a stream-mode push on full keeps the FIFO full and marks overflow
  a_r5_stream_keep: assert property (@(posedge clk) disable iff (!rst_n)
    drop_old |=> (full && ovf_q));
  // R5: overflow flag is sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/wake_fifo_ctrl.sv
module wake_fifo_ctrl
  import wfc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AXW   = 16,
  localparam int SW   = 3 * AXW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SW-1:0]    smp_data,
  input  logic             stream_mode,
  input  logic             wake_evt,
  input  logic             wake_mode_on,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             irq_clr,
  output logic             wake_irq,
  input  logic             rd_en,
  output logic [SW-1:0]    rd_data,
  output logic             fifo_empty,
  output logic             fifo_full,
  output logic [CW-1:0]    fifo_count,
  output logic             fifo_ovf
);
  wfc_cfg_t cfg;
  logic     cap_en, push;

  wfc_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  wfc_wake u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (wake_evt),
    .wake_mode (wake_mode_on),
    .clr       (irq_clr),
    .rearm     (cfg.rearm),
    .irq       (wake_irq)
  );

  assign cap_en = (|cfg.iface) && !(cfg.freeze && wake_irq);
  assign push   = smp_valid && cap_en;

  wfc_fifo #(.DEPTH(DEPTH), .W(SW)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .wdata  (smp_data),
    .pop    (rd_en),
    .stream (stream_mode),
    .rdata  (rd_data),
    .count  (fifo_count),
    .full   (fifo_full),
    .empty  (fifo_empty),
    .ovf    (fifo_ovf)
  );

  // R8: frozen FIFO does not grow
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.freeze && wake_irq && smp_valid && !rd_en) |=> $stable(fifo_count));
  // R3: no interface enabled means no capture
  a_r3_no_iface: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.iface == 3'b000) && !rd_en) |=> $stable(fifo_count));
endmodule

// File: tb/tb_wake_fifo_ctrl.sv
module tb_wake_fifo_ctrl;
  localparam int DEPTH = 32;
  localparam int SW    = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_valid, stream_mode, wake_evt, wake_mode_on;
  logic [SW-1:0] smp_data;
  logic          cfg_we, irq_clr, rd_en;
  logic [7:0]    cfg_wdata, cfg_rdata;
  logic          wake_irq, fifo_empty, fifo_full, fifo_ovf;
  logic [SW-1:0] rd_data;
  logic [5:0]    fifo_count;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  wake_fifo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .stream_mode(stream_mode), .wake_evt(wake_evt), .wake_mode_on(wake_mode_on),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_clr(irq_clr), .wake_irq(wake_irq), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count),
    .fifo_ovf(fifo_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [SW-1:0] d);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic evt();
    wake_evt = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0;
  endtask

  task automatic clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic drain();
    while (!fifo_empty) pop();
  endtask

  task automatic mode_cycle();
    wake_mode_on = 1'b0;
    @(negedge clk);
    wake_mode_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata, 8'h00);
    chk("R1 irq", wake_irq, 1'b0);
    chk("R1 empty", fifo_empty, 1'b1);
    chk("R1 count", fifo_count, 0);
    chk("R1 ovf", fifo_ovf, 1'b0);
  endtask

  task automatic t_cfg();
    wcfg(8'hFF);
    chk("R2 readback ff", cfg_rdata, 8'hF8);
    wcfg(8'h27);
    chk("R2 readback 27", cfg_rdata, 8'h20);
  endtask

  task automatic t_no_iface();
    wcfg(8'h00);
    for (int i = 0; i < 3; i++) push(SW'(i + 7));
    chk("R3 count", fifo_count, 0);
    chk("R3 empty", fifo_empty, 1'b1);
  endtask

  task automatic t_plain();
    wcfg(8'h20);
    stream_mode = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) push(SW'(i));
    chk("R4 count", fifo_count, DEPTH);
    chk("R4 full", fifo_full, 1'b1);
    chk("R4 ovf", fifo_ovf, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R4 order", rd_data, SW'(i));
      pop();
    end
    chk("R4 empty", fifo_empty, 1'b1);
  endtask

  task automatic t_stream();
    stream_mode = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) push(SW'(100 + i));
    chk("R5 count", fifo_count, DEPTH);
    chk("R5 ovf", fifo_ovf, 1'b1);
    chk("R5 head", rd_data, SW'(102));
    drain();
    chk("R5 sticky", fifo_ovf, 1'b1);
  endtask

  task automatic t_wake_and_nofreeze();
    evt();
    chk("R6 ignored outside wake", wake_irq, 1'b0);
    wake_mode_on = 1'b1;
    @(negedge clk);
    evt();
    chk("R6 irq set", wake_irq, 1'b1);
    push(SW'(1)); push(SW'(2));
    chk("R7 capture continues", fifo_count, 2);
    chk("R6 irq held", wake_irq, 1'b1);
    clr();
    chk("R6 irq cleared", wake_irq, 1'b0);
    drain();
  endtask

  task automatic t_no_rearm();
    evt();
    chk("R10 ignored after clear", wake_irq, 1'b0);
    mode_cycle();
    evt();
    chk("R10 armed by mode exit", wake_irq, 1'b1);
    clr();
  endtask

  task automatic t_freeze();
    mode_cycle();
    wcfg(8'h28);
    smp_valid = 1'b1; smp_data = SW'(17); wake_evt = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; wake_evt = 1'b0;
    chk("R8 same-cycle sample kept", fifo_count, 1);
    chk("R8 irq", wake_irq, 1'b1);
    push(SW'(34)); push(SW'(51));
    chk("R8 frozen count", fifo_count, 1);
    chk("R8 head", rd_data, SW'(17));
    pop();
    chk("R8 pop allowed", fifo_count, 0);
    clr();
    push(SW'(68));
    chk("R9 resume count", fifo_count, 1);
    chk("R9 no backfill", rd_data, SW'(68));
    pop();
  endtask

  task automatic t_rearm();
    wcfg(8'h30);
    mode_cycle();
    evt();
    chk("R11 first", wake_irq, 1'b1);
    clr();
    chk("R11 cleared", wake_irq, 1'b0);
    evt();
    chk("R11 second", wake_irq, 1'b1);
  endtask

  task automatic t_collide();
    wake_evt = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0; irq_clr = 1'b0;
    chk("R12 clr wins (irq high)", wake_irq, 1'b0);
    wake_evt = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    wake_evt = 1'b0; irq_clr = 1'b0;
    chk("R12 clr wins (irq low)", wake_irq, 1'b0);
    evt();
    chk("R12 still armed", wake_irq, 1'b1);
    clr();
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; stream_mode = 1'b0;
    wake_evt = 1'b0; wake_mode_on = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    irq_clr = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_no_iface();
    t_plain();
    t_stream();
    wcfg(8'h20);
    t_wake_and_nofreeze();
    t_no_rearm();
    t_freeze();
    t_rearm();
    t_collide();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule